// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler with Conservative Memory Ordering

This block is the issue stage of an out-of-order core. It accepts one renamed instruction per cycle, in program order, into a small queue. Each queued instruction carries its operation class, up to two physical source tags, a physical destination tag and a program-order age. A source counts as ready when the register-ready scoreboard marks it at dispatch, or when a writeback broadcast names it. Every cycle the block grants issue to up to `ISSUE_W` ready instructions, oldest first. One cycle after each grant it broadcasts the destination tag, which wakes the dependents.

Memory operations are ordered conservatively, because addresses are not compared. A load waits until every older store has left the queue. A store waits until every older load and store has left the queue. Two memory operations that might conflict therefore never issue in the same cycle. When all `IQ_DEPTH` slots are occupied the block holds off dispatch. A slot freed by an issue can take a new instruction in the following cycle.

Top module: `oooIssueSched`

## Requirements
- R1: During and directly after reset, no issue grant and no writeback broadcast is asserted, and `dispReady` is high.
- R2: At most `ISSUE_W` instructions are granted per cycle. Slot 0 carries the oldest granted age, and the later slots carry strictly younger ages.
- R3: An instruction dispatched in cycle c whose sources are ready is granted in cycle c+1 at the earliest, and then as soon as its other conditions allow.
- R4: A grant in cycle c of a class 0 (reg-reg), 1 (reg-imm) or 2 (load) instruction raises `wbValid` in the same slot in cycle c+1, with the destination tag on `wbTag`. A class 3 (store) grant raises no broadcast.
- R5: A consumer of a broadcast tag is eligible in the cycle after the broadcast. A dependent chain therefore issues every second cycle.
- R6: A load (class 2) is granted only when every older store has been granted in an earlier cycle.
- R7: A store (class 3) is granted only when every older load and store has been granted in an earlier cycle.
- R8: `dispReady` is low exactly when all `IQ_DEPTH` slots hold instructions. A slot freed by a grant in cycle c accepts dispatch in cycle c+1.
- R9: Classes 1 and 2 use only `dispSrcA`. Their `dispSrcB` value, even when it names a tag that never becomes ready, does not delay them. Classes 0 and 3 wait for both sources.
- R10: When more instructions are eligible than `ISSUE_W`, the oldest ones by age are granted and the rest wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dispValid | input | 1 | A dispatch is offered this cycle |
| dispClass | input | 2 | Class: 0 reg-reg, 1 reg-imm, 2 load, 3 store |
| dispSrcA | input | TAG_W | First physical source tag |
| dispSrcB | input | TAG_W | Second physical source tag (classes 0 and 3) |
| dispDst | input | TAG_W | Physical destination tag (ignored for stores) |
| dispAge | input | AGE_W | Program-order age, increasing |
| regReady | input | NPHYS | Scoreboard: bit t set when tag t holds a value |
| dispReady | output | 1 | A free slot exists; a dispatch is accepted |
| issueValid | output | ISSUE_W | Issue grant per slot |
| issueAge | output | ISSUE_W*AGE_W | Age of the granted instruction per slot |
| wbValid | output | ISSUE_W | Writeback broadcast per slot |
| wbTag | output | ISSUE_W*TAG_W | Broadcast destination tag per slot |

## Verification
The checker enforces on every cycle the properties that need no knowledge of the program. These are the oldest-first ordering across grant slots, broadcasts only after grants, no grant from an empty queue, the stall on a full queue, and the reopening of dispatch after an issue from a full queue. Whether a particular grant was correct depends on dependences, memory classes and ages, so only the bench's scenarios can show it. The bench's scenarios cover dependent chains issuing every second cycle, loads held behind a store, stores held behind loads, an ignored second source, contention for the issue slots, and a queue filled to capacity. Random programs are compared cycle by cycle against an independent model of the rules.

// File: rtl/oooIqPkg.sv
package oooIqPkg;
  localparam int IQ_DEPTH = 8;
  localparam int ISSUE_W  = 2;
  localparam int TAG_W    = 6;
  localparam int AGE_W    = 8;
  localparam int NPHYS    = 1 << TAG_W;
  localparam int IDX_W    = $clog2(IQ_DEPTH);

  typedef enum logic [1:0] {
    CLS_RR = 2'd0,
    CLS_RI = 2'd1,
    CLS_LD = 2'd2,
    CLS_ST = 2'd3
  } opClassE;

  typedef struct packed {
    logic             valid;
    opClassE          cls;
    logic [TAG_W-1:0] srcA;
    logic [TAG_W-1:0] srcB;
    logic [TAG_W-1:0] dst;
    logic             rdyA;
    logic             rdyB;
    logic [AGE_W-1:0] age;
  } iqEntryT;

  // strobes from control to datapath
  typedef struct packed {
    logic [IQ_DEPTH-1:0]             alloc;
    logic [IQ_DEPTH-1:0]             grant;
    logic [ISSUE_W-1:0]              slotValid;
    logic [ISSUE_W-1:0][IDX_W-1:0]   slotIdx;
  } iqStrobeT;

  function automatic logic usesSrcB(opClassE c);
    return (c == CLS_RR) || (c == CLS_ST);
  endfunction

  function automatic logic isMemOp(opClassE c);
    return (c == CLS_LD) || (c == CLS_ST);
  endfunction
endpackage

// File: rtl/iqDatapath.sv
module iqDatapath
  import oooIqPkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  iqStrobeT                        strb,
  input  logic [1:0]                      dispClass,
  input  logic [TAG_W-1:0]                dispSrcA,
  input  logic [TAG_W-1:0]                dispSrcB,
  input  logic [TAG_W-1:0]                dispDst,
  input  logic [AGE_W-1:0]                dispAge,
  input  logic [NPHYS-1:0]                regReady,
  output iqEntryT [IQ_DEPTH-1:0]          q,
  output logic [ISSUE_W-1:0][AGE_W-1:0]   slotAge,
  output logic [ISSUE_W-1:0]              wbValidV,
  output logic [ISSUE_W-1:0][TAG_W-1:0]   wbTagV
);
  iqEntryT newEntry;

  function automatic logic snoop(logic [TAG_W-1:0] t,
                                 logic [ISSUE_W-1:0] v,
                                 logic [ISSUE_W-1:0][TAG_W-1:0] tags);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < ISSUE_W; k++)
      if (v[k] && tags[k] == t) hit = 1'b1;
    return hit;
  endfunction

  always_comb begin
    newEntry.valid = 1'b1;
    newEntry.cls   = opClassE'(dispClass);
    newEntry.srcA  = dispSrcA;
    newEntry.srcB  = dispSrcB;
    newEntry.dst   = dispDst;
    newEntry.age   = dispAge;
    newEntry.rdyA  = regReady[dispSrcA] | snoop(dispSrcA, wbValidV, wbTagV);
    newEntry.rdyB  = !usesSrcB(opClassE'(dispClass)) | regReady[dispSrcB]
                   | snoop(dispSrcB, wbValidV, wbTagV);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= '0;
    end else begin
      for (int e = 0; e < IQ_DEPTH; e++) begin
        if (strb.grant[e]) q[e].valid <= 1'b0;
        for (int k = 0; k < ISSUE_W; k++) begin
          if (wbValidV[k] && wbTagV[k] == q[e].srcA) q[e].rdyA <= 1'b1;
          if (wbValidV[k] && wbTagV[k] == q[e].srcB) q[e].rdyB <= 1'b1;
        end
        if (strb.alloc[e]) q[e] <= newEntry;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValidV <= '0;
      wbTagV   <= '0;
    end else begin
      for (int s = 0; s < ISSUE_W; s++) begin
        wbValidV[s] <= strb.slotValid[s] && (q[strb.slotIdx[s]].cls != CLS_ST);
        wbTagV[s]   <= q[strb.slotIdx[s]].dst;
      end
    end
  end

  always_comb
    for (int s = 0; s < ISSUE_W; s++) slotAge[s] = q[strb.slotIdx[s]].age;
endmodule

// File: rtl/iqControl.sv
module iqControl
  import oooIqPkg::*;
(
  input  iqEntryT [IQ_DEPTH-1:0] q,
  input  logic                   dispValid,
  output iqStrobeT               strb,
  output logic                   dispReady
);
  logic [IQ_DEPTH-1:0] elig;
  logic [IQ_DEPTH-1:0] taken;
  logic                found;
  logic [IDX_W-1:0]    pick;
  logic                allocDone;

  // eligibility: operands ready and no older conflicting memory op queued
  always_comb begin
    for (int e = 0; e < IQ_DEPTH; e++) begin
      elig[e] = q[e].valid && q[e].rdyA && q[e].rdyB;
      if (isMemOp(q[e].cls))
        for (int j = 0; j < IQ_DEPTH; j++)
          if (j != e && q[j].valid && q[j].age < q[e].age &&
              (q[j].cls == CLS_ST ||
               (q[e].cls == CLS_ST && q[j].cls == CLS_LD)))
            elig[e] = 1'b0;
    end
  end

  // oldest-first selection, one pass per issue slot
  always_comb begin
    taken          = '0;
    strb.slotValid = '0;
    strb.slotIdx   = '0;
    for (int s = 0; s < ISSUE_W; s++) begin
      found = 1'b0;
      pick  = '0;
      for (int e = 0; e < IQ_DEPTH; e++)
        if (elig[e] && !taken[e] && (!found || q[e].age < q[pick].age)) begin
          found = 1'b1;
          pick  = IDX_W'(e);
        end
      strb.slotValid[s] = found;
      strb.slotIdx[s]   = pick;
      if (found) taken[pick] = 1'b1;
    end
    strb.grant = taken;
  end

  // first free slot takes the dispatch
  always_comb begin
    dispReady  = 1'b0;
    allocDone  = 1'b0;
    strb.alloc = '0;
    for (int e = 0; e < IQ_DEPTH; e++)
      if (!q[e].valid) begin
        dispReady = 1'b1;
        if (dispValid && !allocDone) begin
          strb.alloc[e] = 1'b1;
          allocDone     = 1'b1;
        end
      end
  end
endmodule

// File: rtl/oooIssueSched.sv
module oooIssueSched
  import oooIqPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       dispValid,
  input  logic [1:0]                 dispClass,
  input  logic [TAG_W-1:0]           dispSrcA,
  input  logic [TAG_W-1:0]           dispSrcB,
  input  logic [TAG_W-1:0]           dispDst,
  input  logic [AGE_W-1:0]           dispAge,
  input  logic [NPHYS-1:0]           regReady,
  output logic                       dispReady,
  output logic [ISSUE_W-1:0]         issueValid,
  output logic [ISSUE_W*AGE_W-1:0]   issueAge,
  output logic [ISSUE_W-1:0]         wbValid,
  output logic [ISSUE_W*TAG_W-1:0]   wbTag
);
  iqStrobeT                       strb;
  iqEntryT [IQ_DEPTH-1:0]         q;
  logic [ISSUE_W-1:0][AGE_W-1:0]  slotAge;
  logic [ISSUE_W-1:0][TAG_W-1:0]  wbTagV;
  logic [IQ_DEPTH-1:0]            occVec;

  iqControl ctrl (
    .q(q), .dispValid(dispValid), .strb(strb), .dispReady(dispReady)
  );

  iqDatapath dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dispClass(dispClass), .dispSrcA(dispSrcA), .dispSrcB(dispSrcB),
    .dispDst(dispDst), .dispAge(dispAge), .regReady(regReady),
    .q(q), .slotAge(slotAge), .wbValidV(wbValid), .wbTagV(wbTagV)
  );

  assign issueValid = strb.slotValid;

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
    assign issueAge[s*AGE_W +: AGE_W] = slotAge[s];
    assign wbTag[s*TAG_W +: TAG_W]    = wbTagV[s];
  end

  for (genvar e = 0; e < IQ_DEPTH; e++) begin : g_occ
    assign occVec[e] = q[e].valid;
  end
endmodule

// File: rtl/iqSchedChecker.sv
module iqSchedChecker
  import oooIqPkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [ISSUE_W-1:0]       issueValid,
  input logic [ISSUE_W*AGE_W-1:0] issueAge,
  input logic [ISSUE_W-1:0]       wbValid,
  input logic                     dispReady,
  input logic [IQ_DEPTH-1:0]      occVec
);
  assert_issue_needs_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|issueValid) |-> (|occVec));

  assert_wb_after_issue_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|wbValid) |-> $past(|issueValid));

  assert_wb_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wbValid) <= $countones($past(issueValid)));

  assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (&occVec) |-> !dispReady);

  assert_refill_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((&occVec) && (|issueValid)) |=> dispReady);

  for (genvar s = 1; s < ISSUE_W; s++) begin : g_ord
    assert_oldest_slot_R10: assert property (@(posedge clk) disable iff (!rstN)
      issueValid[s] |-> (issueValid[s-1] &&
        issueAge[(s-1)*AGE_W +: AGE_W] < issueAge[s*AGE_W +: AGE_W]));
  end
endmodule

bind oooIssueSched iqSchedChecker chkI (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueAge(issueAge),
  .wbValid(wbValid), .dispReady(dispReady), .occVec(occVec)
);

// File: tb/oooIssueSched_test.sv
module oooIssueSched_test;
  import oooIqPkg::*;

  localparam int PMAX  = 64;
  localparam int NDIR  = 17;
  localparam int NEVER = 1000000;

  // directed program rows: {class, srcA, srcB, expected issue cycle}
  localparam logic [21:0] DIR_TBL [NDIR] = '{
    {2'd0, 6'd1,  6'd2,  8'd1}, {2'd1, 6'd32, 6'd0,  8'd3}, {2'd0, 6'd33, 6'd32, 8'd5},
    {2'd1, 6'd1,  6'd0,  8'd1}, {2'd3, 6'd32, 6'd2,  8'd3}, {2'd2, 6'd3,  6'd0,  8'd4},
    {2'd2, 6'd4,  6'd0,  8'd4}, {2'd1, 6'd5,  6'd0,  8'd5}, {2'd3, 6'd6,  6'd7,  8'd6},
    {2'd1, 6'd1,  6'd40, 8'd1}, {2'd2, 6'd2,  6'd45, 8'd2}, {2'd0, 6'd3,  6'd4,  8'd3},
    {2'd1, 6'd1,  6'd0,  8'd1}, {2'd1, 6'd32, 6'd0,  8'd3}, {2'd0, 6'd33, 6'd1,  8'd5},
    {2'd0, 6'd33, 6'd2,  8'd5}, {2'd0, 6'd33, 6'd3,  8'd6}
  };
  localparam int    P_START [4] = '{0, 3, 9, 12};
  localparam int    P_LEN   [4] = '{3, 6, 3, 5};
  localparam string P_TAG   [4] = '{"R5", "R7", "R9", "R10"};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispValid = 1'b0;
  logic [1:0] dispClass = '0;
  logic [TAG_W-1:0] dispSrcA = '0, dispSrcB = '0, dispDst = '0;
  logic [AGE_W-1:0] dispAge = '0;
  logic [NPHYS-1:0] regReady = '0;
  logic dispReady;
  logic [ISSUE_W-1:0] issueValid, wbValid;
  logic [ISSUE_W*AGE_W-1:0] issueAge;
  logic [ISSUE_W*TAG_W-1:0] wbTag;

  int total = 0;
  int bad = 0;
  int pCls[PMAX], pA[PMAX], pB[PMAX], pExp[PMAX];
  int dispC[PMAX], issC[PMAX], dutIss[PMAX];
  int tagRdy[NPHYS];
  logic [NPHYS-1:0] sbReady;

  always #5 clk = ~clk;

  oooIssueSched uut (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispClass(dispClass),
    .dispSrcA(dispSrcA), .dispSrcB(dispSrcB), .dispDst(dispDst), .dispAge(dispAge),
    .regReady(regReady), .dispReady(dispReady), .issueValid(issueValid),
    .issueAge(issueAge), .wbValid(wbValid), .wbTag(wbTag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit needsB(int c);
    return c == 0 || c == 3;
  endfunction

  task automatic runProg(input int n, input string tag);
    int eg[ISSUE_W], prevG[ISSUE_W];
    int egN, prevN, nx, occ, tail;
    bit ok;
    rstN = 1'b0; dispValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(issueValid == '0, "R1", "reset grant", int'(issueValid), 0);
    chk(wbValid == '0, "R1", "reset wb", int'(wbValid), 0);
    chk(dispReady == 1'b1, "R1", "reset dispReady", int'(dispReady), 1);
    for (int t = 0; t < NPHYS; t++) tagRdy[t] = (t < 32) ? 0 : NEVER;
    for (int i = 0; i < PMAX; i++) begin dispC[i] = -1; issC[i] = -1; dutIss[i] = -1; end
    sbReady = '0;
    for (int t = 0; t < 32; t++) sbReady[t] = 1'b1;
    regReady = sbReady;
    rstN = 1'b1;
    prevN = 0; nx = 0; tail = 0;
    @(posedge clk);
    for (int c = 0; c < 400 && tail < 3; c++) begin
      @(negedge clk);
      egN = 0;
      for (int i = 0; i < n; i++) begin
        ok = dispC[i] >= 0 && dispC[i] < c && issC[i] < 0 && tagRdy[32'(pA[i])] <= c &&
             (!needsB(pCls[i]) || tagRdy[32'(pB[i])] <= c);
        if (pCls[i] >= 2)
          for (int j = 0; j < i; j++)
            if (issC[j] < 0 && (pCls[j] == 3 || (pCls[i] == 3 && pCls[j] == 2))) ok = 0;
        if (ok && egN < ISSUE_W) begin eg[egN] = i; egN++; end
      end
      for (int s = 0; s < ISSUE_W; s++) begin
        chk(issueValid[s] == (s < egN), "R2", "grant valid", int'(issueValid[s]), int'(s < egN));
        if (issueValid[s] && s < egN)
          chk(int'(issueAge[s*AGE_W +: AGE_W]) == eg[s], "R2", "grant age",
              int'(issueAge[s*AGE_W +: AGE_W]), eg[s]);
        if (issueValid[s]) dutIss[int'(issueAge[s*AGE_W +: AGE_W]) % PMAX] = c;
        ok = s < prevN && pCls[prevG[s]] != 3;
        chk(wbValid[s] == ok, "R4", "wb valid", int'(wbValid[s]), int'(ok));
        if (ok && wbValid[s])
          chk(int'(wbTag[s*TAG_W +: TAG_W]) == 32 + prevG[s], "R4", "wb tag",
              int'(wbTag[s*TAG_W +: TAG_W]), 32 + prevG[s]);
      end
      occ = 0;
      for (int i = 0; i < n; i++) if (dispC[i] >= 0 && issC[i] < 0) occ++;
      chk(dispReady == (occ < IQ_DEPTH), "R8", "dispReady", int'(dispReady), int'(occ < IQ_DEPTH));
      for (int s = 0; s < egN; s++) begin
        issC[eg[s]] = c;
        if (pCls[eg[s]] != 3) tagRdy[32 + eg[s]] = c + 2;
        prevG[s] = eg[s];
      end
      prevN = egN;
      regReady = sbReady;
      for (int s = 0; s < ISSUE_W; s++)
        if (wbValid[s]) sbReady[wbTag[s*TAG_W +: TAG_W]] = 1'b1;
      if (nx < n) begin
        dispValid = 1'b1; dispClass = 2'(pCls[nx]);
        dispSrcA = TAG_W'(pA[nx]); dispSrcB = TAG_W'(pB[nx]);
        dispDst = TAG_W'(32 + nx); dispAge = AGE_W'(nx);
        if (occ < IQ_DEPTH) begin dispC[nx] = c; nx++; end
      end else dispValid = 1'b0;
      ok = 1;
      for (int i = 0; i < n; i++) if (issC[i] < 0) ok = 0;
      if (ok && nx == n) tail++;
    end
    for (int i = 0; i < n; i++) begin
      chk(dutIss[i] >= 0 && dutIss[i] == issC[i], "R3", "issue cycle vs model", dutIss[i], issC[i]);
      if (pExp[i] >= 0)
        chk(dutIss[i] == pExp[i], pCls[i] == 2 ? "R6" : (pCls[i] == 3 ? "R7" : tag),
            "issue cycle vs table", dutIss[i], pExp[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // directed table programs
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < P_LEN[p]; i++) begin
        pCls[i] = int'(DIR_TBL[P_START[p] + i][21:20]);
        pA[i]   = int'(DIR_TBL[P_START[p] + i][19:14]);
        pB[i]   = int'(DIR_TBL[P_START[p] + i][13:8]);
        pExp[i] = int'(DIR_TBL[P_START[p] + i][7:0]);
      end
      runProg(P_LEN[p], P_TAG[p]);
    end
    // R8: long dependent chain fills the queue; each link issues at 1+2k
    for (int i = 0; i < 20; i++) begin
      pCls[i] = 1; pA[i] = (i == 0) ? 1 : 31 + i; pB[i] = 0; pExp[i] = 1 + 2 * i;
    end
    runProg(20, "R8");
    // R3: random dependency mixes against the model
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 30; i++) begin
        int j;
        pCls[i] = $urandom_range(0, 3); pExp[i] = -1;
        j = (i > 0) ? $urandom_range(0, i - 1) : 0;
        pA[i] = (i > 0 && pCls[j] != 3 && $urandom_range(0, 1) == 1) ? 32 + j
                                                                      : $urandom_range(0, 31);
        j = (i > 0) ? $urandom_range(0, i - 1) : 0;
        pB[i] = (i > 0 && pCls[j] != 3 && $urandom_range(0, 2) != 0) ? 32 + j
                                                                      : $urandom_range(0, 31);
      end
      runProg(30, "R3");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule